// File: doc/BRIEF.md
# Ethernet MAC Diagnostic Control Register

This block is an 8-bit control register that the host writes to set the diagnostic behaviour of an Ethernet MAC. It holds six fields: a loopback mode selector, a switch that gives the frame check sequence engine to the receive side, a forced-collision request, permission to pass undersized frames, an enable for a reserved test-register space, and a lockout bit for that space. The MAC datapath reads the field values directly. The register also decodes the loopback mode into separate strobes, one for each loopback level.

The lockout bit can be set but never cleared by a write. Once it is set, the test-register grant stays low no matter what the enable holds. Writes can no longer clear the lockout; only the reset pin or a software reset strobe can. The test-access grant is what an address decoder elsewhere uses to admit or refuse host cycles to the test space. The reset pin and the software reset strobe each return every field to zero.

Top module: `diag_ctl_reg`

## Requirements
- R1: While the asynchronous active-low reset `rst_n` is asserted, and in the first cycle after it is released, every field, `rd_data`, `test_grant` and every loopback strobe read 0.
- R2: A write (`wr_en`=1, `sw_rst`=0) stores the fields at the clock edge, and they read back on `rd_data` at these positions: bit 7 test enable, bit 5 runt accept, bit 4 force collision, bit 3 receive-side FCS select, bits 2:1 loopback mode. Each field also appears on its own output.
- R3: Bit 0 is reserved. It always reads 0 and a write of 1 to it has no effect.
- R4: `test_grant` is 1 exactly when the enable (bit 7) is 1 and the lockout (bit 6) is 0. It takes its new value in the cycle after the write edge.
- R5: Writing 1 to bit 6 sets the lockout. Later writes with bit 6 = 0 leave it set, and it reads back as 1.
- R6: While the lockout is set, `test_grant` is 0. The enable bit can still be written and read back.
- R7: A `sw_rst` pulse clears every field, including the lockout, at the next edge. It wins over a write in the same cycle.
- R8: Loopback mode 00 = none (all strobes 0), 01 = external (`loop_ext`), 10 = internal without encoder/decoder (`loop_int_raw`), 11 = internal with encoder/decoder (`loop_int_coded`). At most one strobe is high at a time.
- R9: `fcs_to_rx` is 1 only when the receive-side FCS select bit is 1 and the loopback mode is not 00. The raw bit still reads back unchanged.
- R10: A hardware reset through `rst_n` clears a set lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_rst | input | 1 | Synchronous software reset strobe |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Current register contents |
| test_en | output | 1 | Test-register enable field |
| test_lock | output | 1 | Sticky test-register lockout |
| test_grant | output | 1 | Test-register access permitted |
| runt_accept | output | 1 | Pass undersized frames |
| coll_force | output | 1 | Force collision on next transmit attempt |
| fcs_rx_sel | output | 1 | Raw receive-side FCS select field |
| fcs_to_rx | output | 1 | FCS engine given to receiver (loopback only) |
| loop_mode | output | 2 | Loopback mode field |
| loop_ext | output | 1 | External loopback active |
| loop_int_raw | output | 1 | Internal loopback bypassing encoder/decoder |
| loop_int_coded | output | 1 | Internal loopback through encoder/decoder |

## Verification
The bench writes all-ones, all-zeros and alternating patterns, so a swapped or stuck field position and a writable reserved bit both show up in the read-back. It then walks all four loopback codes, with and without the FCS select bit, to separate the strobe decode from the FCS gating. Lockout sequences set the enable first and the lockout after, then try to clear the lockout with writes. These are followed by a software reset, a software reset in the same cycle as a write, and a pin reset, so the sticky path can be told apart from an ordinary field.

// File: rtl/diag_ctl_reg.sv
module diag_ctl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       test_en,
  output logic       test_lock,
  output logic       test_grant,
  output logic       runt_accept,
  output logic       coll_force,
  output logic       fcs_rx_sel,
  output logic       fcs_to_rx,
  output logic [1:0] loop_mode,
  output logic       loop_ext,
  output logic       loop_int_raw,
  output logic       loop_int_coded
);

  localparam int B_EN   = 7;
  localparam int B_LOCK = 6;
  localparam int B_RUNT = 5;
  localparam int B_COLL = 4;
  localparam int B_FCS  = 3;
  localparam int B_LPHI = 2;
  localparam int B_LPLO = 1;

  localparam logic [1:0] LP_NONE  = 2'b00;
  localparam logic [1:0] LP_EXT   = 2'b01;
  localparam logic [1:0] LP_RAW   = 2'b10;
  localparam logic [1:0] LP_CODED = 2'b11;

  logic       en_q, lock_q, runt_q, coll_q, fcs_q;
  logic [1:0] loop_q;
  logic       take;
  logic       unused_rsvd;

  assign take        = wr_en & ~sw_rst;
  assign unused_rsvd = wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      runt_q <= 1'b0;
      coll_q <= 1'b0;
      fcs_q  <= 1'b0;
      loop_q <= LP_NONE;
    end else if (sw_rst) begin
      en_q   <= 1'b0;
      runt_q <= 1'b0;
      coll_q <= 1'b0;
      fcs_q  <= 1'b0;
      loop_q <= LP_NONE;
    end else if (take) begin
      en_q   <= wr_data[B_EN];
      runt_q <= wr_data[B_RUNT];
      coll_q <= wr_data[B_COLL];
      fcs_q  <= wr_data[B_FCS];
      loop_q <= wr_data[B_LPHI:B_LPLO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lock_q <= 1'b0;
    else if (sw_rst)
      lock_q <= 1'b0;
    else if (take && wr_data[B_LOCK])
      lock_q <= 1'b1;
  end

  assign rd_data = {en_q, lock_q, runt_q, coll_q, fcs_q, loop_q, 1'b0};

  assign test_en     = en_q;
  assign test_lock   = lock_q;
  assign test_grant  = en_q & ~lock_q;
  assign runt_accept = runt_q;
  assign coll_force  = coll_q;
  assign fcs_rx_sel  = fcs_q;
  assign loop_mode   = loop_q;

  assign loop_ext       = (loop_q == LP_EXT);
  assign loop_int_raw   = (loop_q == LP_RAW);
  assign loop_int_coded = (loop_q == LP_CODED);
  assign fcs_to_rx      = fcs_q & (loop_q != LP_NONE);

endmodule

// File: rtl/diag_ctl_reg_chk.sv
module diag_ctl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       test_grant,
  input logic       fcs_to_rx,
  input logic       loop_ext,
  input logic       loop_int_raw,
  input logic       loop_int_coded
);

  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[6] && !sw_rst) |=> rd_data[6]);

  // R6
  lock_denies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6] |-> !test_grant);

  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[0]) |=> !rd_data[0]);

  // R7
  swrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (rd_data == 8'h00 && !test_grant));

  // R4
  grant_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sw_rst && wr_data[7] && !wr_data[6] && !rd_data[6]) |=> test_grant);

  // R8
  loop_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({loop_ext, loop_int_raw, loop_int_coded}));

  // R9
  fcs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fcs_to_rx |-> (rd_data[3] && rd_data[2:1] != 2'b00));

endmodule

bind diag_ctl_reg diag_ctl_reg_chk i_chk (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .test_grant(test_grant), .fcs_to_rx(fcs_to_rx),
  .loop_ext(loop_ext), .loop_int_raw(loop_int_raw), .loop_int_coded(loop_int_coded)
);

// File: tb/test_diag_ctl_reg.sv
module test_diag_ctl_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_rst = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic test_en, test_lock, test_grant, runt_accept, coll_force;
  logic fcs_rx_sel, fcs_to_rx, loop_ext, loop_int_raw, loop_int_coded;
  logic [1:0] loop_mode;

  always #2 clk = ~clk;

  diag_ctl_reg i_diag_ctl_reg (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .test_en(test_en), .test_lock(test_lock),
    .test_grant(test_grant), .runt_accept(runt_accept), .coll_force(coll_force),
    .fcs_rx_sel(fcs_rx_sel), .fcs_to_rx(fcs_to_rx), .loop_mode(loop_mode),
    .loop_ext(loop_ext), .loop_int_raw(loop_int_raw), .loop_int_coded(loop_int_coded)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] model = 8'h00;
  logic [20:0] exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  function automatic logic [20:0] expect_of(input logic [7:0] m);
    logic [1:0] lp;
    lp = m[2:1];
    return {m, m[7] & ~m[6], m[7], m[6], m[5], m[4], m[3], lp,
            m[3] & (lp != 2'b00), lp == 2'b01, lp == 2'b10, lp == 2'b11};
  endfunction

  function automatic logic [20:0] observed();
    return {rd_data, test_grant, test_en, test_lock, runt_accept, coll_force,
            fcs_rx_sel, loop_mode, fcs_to_rx, loop_ext, loop_int_raw, loop_int_coded};
  endfunction

  task automatic op(input bit sw, input bit wr, input logic [7:0] d, input string tag);
    @(negedge clk);
    sw_rst = sw; wr_en = wr; wr_data = d;
    @(posedge clk);
    #1;
    if (sw) model = 8'h00;
    else if (wr) model = {d[7], model[6] | d[6], d[5:1], 1'b0};
    sw_rst = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    exp_q.push_back(expect_of(model));
    tag_q.push_back(tag);
  endtask

  task automatic pin_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    checks++;
    if (observed() != 21'h0) begin
      errors++;
      $display("FAIL %s: in reset got %h expected %h", tag, observed(), 21'h0);
    end
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    model = 8'h00;
    exp_q.push_back(expect_of(model));
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [20:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (observed() !== e) begin
        errors++;
        $display("FAIL %s: got %h expected %h", t, observed(), e);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    pin_reset("R1 reset state");
    op(0, 0, 8'h00, "R1 idle after reset");
    op(0, 1, 8'hBF, "R2 all fields set, R4 grant, R3 bit0");
    op(0, 1, 8'h00, "R2 all cleared");
    op(0, 1, 8'hAA, "R2 pattern AA");
    op(0, 1, 8'h15, "R2 pattern 15 R3 bit0 ignored");
    op(0, 1, 8'h01, "R3 reserved write only");
    op(0, 1, 8'h02, "R8 external loop");
    op(0, 1, 8'h04, "R8 internal raw loop");
    op(0, 1, 8'h06, "R8 internal coded loop");
    op(0, 1, 8'h08, "R9 fcs select without loopback");
    op(0, 1, 8'h0A, "R9 fcs select with external loop");
    op(0, 1, 8'h0E, "R9 fcs select with coded loop");
    op(0, 1, 8'h80, "R4 enable grants");
    op(0, 1, 8'hC0, "R5 lockout set R6 denied");
    op(0, 1, 8'h80, "R5 lockout survives clear attempt");
    op(0, 1, 8'h00, "R6 enable cleared under lockout");
    op(0, 1, 8'h80, "R6 enable rewritten under lockout");
    op(1, 0, 8'h00, "R7 software reset clears lockout");
    op(0, 1, 8'h80, "R4 grant returns after reset");
    op(0, 1, 8'hFE, "R5 lockout set again");
    op(1, 1, 8'hBE, "R7 software reset beats write");
    op(0, 1, 8'h40, "R5 lockout alone");
    pin_reset("R10 pin reset in lockout");
    op(0, 1, 8'h80, "R10 grant after pin reset");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule